// File: doc/BRIEF.md
# Resource Unit Selector

This block tracks the units of a single execution resource and decides which unit serves the next request. The resource is either a plain resource built from several identical units or a group whose members are themselves resources. Each unit is one bit of a unit vector, with bit i standing for unit i. The block keeps three masks. A rotating sequence mask names the units still due in the current round. A free mask marks the units that are not in use. A dropped mask records units that were claimed by a fixed binding while they were already out of the rotation.

A request may ask the block to choose a unit, which it takes from the highest set bit of the sequence mask. A request may instead bind a named unit. Units are also handed back with a release. A combinational ready output tells whether the resource can take a requested number of units. That output takes a reservation flag into account, and the flag is ignored when the resource is configured as a dispatch hazard. The shape of the resource and its hazard behaviour are set by parameters.

Top module: `unit_pick_sel`

## Requirements
- R1: The full unit mask is (1<<NUM_UNITS)-1 for a plain resource (IS_GROUP=0), and GROUP_MASK with its highest set bit cleared for a group (IS_GROUP=1). After reset the sequence mask and the free mask both equal the full mask, the dropped mask is zero and the error flag is low.
- R2: While sel_req is high and bind_req is low, sel_unit shows the highest set bit of the sequence mask in the same cycle. At the next clock edge that bit is cleared from the sequence mask and from the free mask.
- R3: When the sequence mask becomes zero, it is reloaded at the same edge with the full mask minus the dropped mask, or with the full mask if that difference is zero. The dropped mask is then cleared.
- R4: A bind (bind_req, one-hot bind_unit) clears that unit from the free mask. It also clears the unit from the sequence mask when the unit is still in it. Otherwise the unit is added to the dropped mask and the sequence mask is left unchanged.
- R5: A release (rel_req, one-hot rel_unit) sets that unit's bit in the free mask again.
- R6: ready is high exactly when (reserved is low or DISPATCH_HAZARD=1) and the number of set bits in the free mask is at least need_cnt.
- R7: The error flag err is set and stays high until reset, and the cycle leaves all three masks unchanged, in any of these cases: a unit is used (by selection or bind) while it is not free; a bind or release names a value that is not a single unit of the full mask; a release names a unit that is already free. A release is applied before the use in the same cycle.
- R8: When sel_req and bind_req are both high, the bind is performed, the selection is not performed, and sel_unit is zero.
- R9: sel_unit is zero whenever sel_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_req | input | 1 | Choose and use the next unit in the rotation |
| bind_req | input | 1 | Use the unit named on bind_unit |
| bind_unit | input | WIDTH | One-hot unit to bind |
| rel_req | input | 1 | Hand back the unit on rel_unit |
| rel_unit | input | WIDTH | One-hot unit to release |
| reserved | input | 1 | Resource held by another user |
| need_cnt | input | CNT_W | Number of units asked for by the ready query |
| sel_unit | output | WIDTH | One-hot chosen unit, zero when none |
| ready | output | 1 | Enough free units and not blocked by a reservation |
| err | output | 1 | Sticky misuse flag |

## Verification
The bench builds two copies of the block. The first is a plain four-bit resource with three units, so the top bit lies outside the full mask. On this copy a hold on the reservation blocks ready, and the rotation, the bind path, the dropped-unit reload and the misuse cases are all exercised. The second is a six-bit group with mask 101101 and the hazard option set. It shows that the top group bit is removed from the rotation, that the remaining sparse bits are walked from the highest down, and that a reservation does not block ready.

// File: rtl/unit_pick_pkg.sv
package unit_pick_pkg;

    // Isolate the highest set bit of a 64-bit value.
    function automatic logic [63:0] top_bit64(input logic [63:0] v);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 64; i++) begin
            if (v[i]) r = 64'(1) << i;
        end
        return r;
    endfunction

    // Full unit mask for a plain resource or a group.
    function automatic logic [63:0] full_units(input bit grp, input int n,
                                               input logic [63:0] gm);
        if (grp) return gm ^ top_bit64(gm);
        return (64'(1) << n) - 64'(1);
    endfunction

endpackage

// File: rtl/unit_msb_isolate.sv
module unit_msb_isolate #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [WIDTH-1:0] top_o
);
    logic [WIDTH-1:0] above;

    assign above[WIDTH-1] = 1'b0;
    assign top_o[WIDTH-1] = vec_i[WIDTH-1];

    generate
        for (genvar i = WIDTH - 2; i >= 0; i--) begin : g_bit
            assign above[i] = above[i+1] | vec_i[i+1];
            assign top_o[i] = vec_i[i] & ~above[i];
        end
    endgenerate

    // R2
    always_comb begin
        top_onehot_chk: assert ($onehot0(top_o));
    end
endmodule

// File: rtl/unit_popcount.sv
module unit_popcount #(
    parameter int WIDTH = 8,
    parameter int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < WIDTH; i++) begin
            cnt_o = cnt_o + CNT_W'(vec_i[i]);
        end
    end
endmodule

// File: rtl/unit_pick_sel.sv
module unit_pick_sel #(
    parameter int              WIDTH           = 8,
    parameter bit              IS_GROUP        = 1'b0,
    parameter int              NUM_UNITS       = 4,
    parameter logic [WIDTH-1:0] GROUP_MASK     = 8'hB4,
    parameter bit              DISPATCH_HAZARD = 1'b0,
    parameter int              CNT_W           = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_req,
    input  logic             bind_req,
    input  logic [WIDTH-1:0] bind_unit,
    input  logic             rel_req,
    input  logic [WIDTH-1:0] rel_unit,
    input  logic             reserved,
    input  logic [CNT_W-1:0] need_cnt,
    output logic [WIDTH-1:0] sel_unit,
    output logic             ready,
    output logic             err
);
    import unit_pick_pkg::*;

    localparam logic [WIDTH-1:0] FULL =
        WIDTH'(full_units(IS_GROUP, NUM_UNITS, 64'(GROUP_MASK)));

    typedef struct packed {
        logic [WIDTH-1:0] seq;
        logic [WIDTH-1:0] free;
        logic [WIDTH-1:0] dropped;
        logic             err;
    } state_t;

    state_t st_q, st_d;

    logic [WIDTH-1:0] pick;
    logic [CNT_W-1:0] free_cnt;

    function automatic logic is_unit(input logic [WIDTH-1:0] u);
        return (u != '0) && ((u & (u - 1'b1)) == '0) && ((u & ~FULL) == '0);
    endfunction

    unit_msb_isolate #(.WIDTH(WIDTH)) u_pick (
        .vec_i (st_q.seq),
        .top_o (pick)
    );

    unit_popcount #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_cnt (
        .vec_i (st_q.free),
        .cnt_o (free_cnt)
    );

    assign sel_unit = (sel_req && !bind_req) ? pick : '0;
    assign ready    = (!reserved || DISPATCH_HAZARD) && (free_cnt >= need_cnt);
    assign err      = st_q.err;

    always_comb begin
        logic [WIDTH-1:0] use_u;
        logic [WIDTH-1:0] free_rel;
        logic [WIDTH-1:0] seq_n;
        logic [WIDTH-1:0] refill;
        logic             do_use;
        logic             rel_bad;
        logic             use_bad;

        st_d     = st_q;
        do_use   = bind_req || sel_req;
        use_u    = bind_req ? bind_unit : (sel_req ? pick : '0);
        rel_bad  = rel_req && !(is_unit(rel_unit) && ((st_q.free & rel_unit) == '0));
        free_rel = rel_req ? (st_q.free | rel_unit) : st_q.free;
        use_bad  = do_use && !(is_unit(use_u) && ((free_rel & use_u) != '0));
        refill   = ((FULL & ~st_q.dropped) != '0) ? (FULL & ~st_q.dropped) : FULL;
        seq_n    = st_q.seq;

        if (rel_bad || use_bad) begin
            st_d.err = 1'b1;
        end else begin
            st_d.free = free_rel & ~use_u;
            if (bind_req) begin
                if ((st_q.seq & bind_unit) != '0) seq_n = st_q.seq & ~bind_unit;
                else st_d.dropped = st_q.dropped | bind_unit;
            end else if (sel_req) begin
                seq_n = st_q.seq & ~pick;
            end
            if (seq_n == '0) begin
                seq_n        = refill;
                st_d.dropped = '0;
            end
            st_d.seq = seq_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.seq     <= FULL;
            st_q.free    <= FULL;
            st_q.dropped <= '0;
            st_q.err     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_unit != '0) |-> (sel_req && !bind_req));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R1
    free_in_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.free & ~FULL) == '0);

    // R3
    seq_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seq != '0);

    // R5
    rel_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && !bind_req && !sel_req && is_unit(rel_unit) &&
         ((st_q.free & rel_unit) == '0))
        |=> ((st_q.free & $past(rel_unit)) != '0));

    // R4
    bind_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bind_req && !rel_req && is_unit(bind_unit) &&
         ((st_q.free & bind_unit) != '0))
        |=> ((st_q.free & $past(bind_unit)) == '0));
endmodule

// File: tb/tb_unit_pick_sel.sv
module tb_unit_pick_sel;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       p_sel = 0, p_bind = 0, p_rel = 0, p_resv = 0;
    logic [3:0] p_bunit = 0, p_runit = 0, p_unit;
    logic [2:0] p_need = 0;
    logic       p_rdy, p_err;

    logic       g_sel = 0, g_bind = 0, g_rel = 0, g_resv = 0;
    logic [5:0] g_bunit = 0, g_runit = 0, g_unit;
    logic [2:0] g_need = 0;
    logic       g_rdy, g_err;

    int checks = 0, fails = 0;
    bit done = 0;

    unit_pick_sel #(.WIDTH(4), .IS_GROUP(1'b0), .NUM_UNITS(3),
                    .GROUP_MASK(4'h0), .DISPATCH_HAZARD(1'b0), .CNT_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .sel_req(p_sel), .bind_req(p_bind),
        .bind_unit(p_bunit), .rel_req(p_rel), .rel_unit(p_runit),
        .reserved(p_resv), .need_cnt(p_need), .sel_unit(p_unit),
        .ready(p_rdy), .err(p_err));

    unit_pick_sel #(.WIDTH(6), .IS_GROUP(1'b1), .NUM_UNITS(1),
                    .GROUP_MASK(6'b101101), .DISPATCH_HAZARD(1'b1), .CNT_W(3)) dut_grp (
        .clk(clk), .rst_n(rst_n), .sel_req(g_sel), .bind_req(g_bind),
        .bind_unit(g_bunit), .rel_req(g_rel), .rel_unit(g_runit),
        .reserved(g_resv), .need_cnt(g_need), .sel_unit(g_unit),
        .ready(g_rdy), .err(g_err));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    // one plain-instance cycle: drive at negedge, check chosen unit, clear after edge
    task automatic p_cyc(input logic s, input logic b, input logic [3:0] bu,
                         input logic r, input logic [3:0] ru,
                         input logic [3:0] exp_unit, input string req);
        @(negedge clk);
        p_sel = s; p_bind = b; p_bunit = bu; p_rel = r; p_runit = ru;
        #1 check(req, 8'(p_unit), 8'(exp_unit));
        @(posedge clk);
        #1 p_sel = 0; p_bind = 0; p_rel = 0; p_bunit = 0; p_runit = 0;
    endtask

    task automatic g_cyc(input logic s, input logic r, input logic [5:0] ru,
                         input logic [5:0] exp_unit, input string req);
        @(negedge clk);
        g_sel = s; g_rel = r; g_runit = ru;
        #1 check(req, 8'(g_unit), 8'(exp_unit));
        @(posedge clk);
        #1 g_sel = 0; g_rel = 0; g_runit = 0;
    endtask

    task automatic p_ready(input logic [2:0] n, input logic exp, input string req);
        @(negedge clk);
        p_need = n;
        #1 check(req, 8'(p_rdy), 8'(exp));
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        p_sel = 0;
        #1 check("R9 idle sel_unit", 8'(p_unit), 8'h0);
        check("R1 err after reset", 8'(p_err), 8'h0);
        p_ready(3'd3, 1'b1, "R1 three units free");
        p_ready(3'd4, 1'b0, "R1 top bit outside full mask");
    endtask

    task automatic t_rotation();
        do_reset();
        p_cyc(1, 0, 0, 0, 0, 4'b0100, "R2 first pick highest");
        p_ready(3'd3, 1'b0, "R2 used unit not free");
        p_ready(3'd2, 1'b1, "R6 two free");
        p_cyc(1, 0, 0, 1, 4'b0100, 4'b0010, "R2 second pick");
        p_cyc(1, 0, 0, 1, 4'b0010, 4'b0001, "R2 third pick");
        p_cyc(1, 0, 0, 1, 4'b0001, 4'b0100, "R3 reload after empty");
        p_cyc(0, 0, 0, 1, 4'b0100, 4'b0000, "R9 release only");
        p_ready(3'd3, 1'b1, "R5 all released");
    endtask

    task automatic t_bind_in_seq();
        do_reset();
        p_cyc(0, 1, 4'b0100, 0, 0, 4'b0000, "R4 bind in sequence");
        p_ready(3'd3, 1'b0, "R4 bound unit not free");
        p_cyc(1, 0, 0, 1, 4'b0100, 4'b0010, "R4 bound unit left rotation");
        p_cyc(1, 0, 0, 1, 4'b0010, 4'b0001, "R4 next pick");
        p_cyc(1, 0, 0, 1, 4'b0001, 4'b0100, "R3 full reload");
        p_cyc(0, 0, 0, 1, 4'b0100, 4'b0000, "R5 release");
    endtask

    task automatic t_bind_dropped();
        do_reset();
        p_cyc(1, 0, 0, 0, 0, 4'b0100, "R2 pick");
        p_cyc(0, 0, 0, 1, 4'b0100, 4'b0000, "R5 release");
        p_cyc(0, 1, 4'b0100, 0, 0, 4'b0000, "R4 bind already out");
        p_cyc(1, 0, 0, 1, 4'b0100, 4'b0010, "R4 sequence unchanged");
        p_cyc(1, 0, 0, 1, 4'b0010, 4'b0001, "R4 pick");
        p_cyc(1, 0, 0, 1, 4'b0001, 4'b0010, "R3 dropped unit removed on reload");
        p_cyc(1, 0, 0, 1, 4'b0010, 4'b0001, "R3 pick");
        p_cyc(1, 0, 0, 1, 4'b0001, 4'b0100, "R3 dropped mask cleared");
        p_cyc(0, 0, 0, 1, 4'b0100, 4'b0000, "R5 release");
        check("R7 no error in legal use", 8'(p_err), 8'h0);
    endtask

    task automatic t_errors();
        do_reset();
        p_cyc(0, 0, 0, 1, 4'b0001, 4'b0000, "R7 release of free unit");
        check("R7 err raised", 8'(p_err), 8'h1);
        p_ready(3'd3, 1'b1, "R7 free mask kept");
        p_cyc(1, 0, 0, 0, 0, 4'b0100, "R7 pick after error");
        p_cyc(0, 1, 4'b0100, 0, 0, 4'b0000, "R7 bind of used unit");
        p_ready(3'd2, 1'b1, "R7 free mask kept after bad bind");
        p_ready(3'd3, 1'b0, "R7 bound unit not freed");
        p_cyc(1, 0, 0, 1, 4'b0100, 4'b0010, "R7 sequence kept");
        p_cyc(1, 0, 0, 1, 4'b0010, 4'b0001, "R7 pick");
        p_cyc(1, 0, 0, 1, 4'b0001, 4'b0100, "R7 bad bind left no dropped bit");
        check("R7 err sticky", 8'(p_err), 8'h1);
        do_reset();
        p_cyc(0, 1, 4'b1000, 0, 0, 4'b0000, "R7 bind outside full mask");
        check("R7 err on bad unit", 8'(p_err), 8'h1);
    endtask

    task automatic t_priority();
        do_reset();
        p_cyc(1, 1, 4'b0001, 0, 0, 4'b0000, "R8 bind wins");
        p_ready(3'd3, 1'b0, "R8 bind performed");
        p_cyc(1, 0, 0, 0, 0, 4'b0100, "R8 selection not performed");
        p_ready(3'd2, 1'b0, "R8 two units used");
    endtask

    task automatic t_reserved();
        do_reset();
        @(negedge clk);
        p_resv = 1; p_need = 3'd1; g_resv = 1; g_need = 3'd1;
        #1 check("R6 plain blocked by reservation", 8'(p_rdy), 8'h0);
        check("R6 hazard ignores reservation", 8'(g_rdy), 8'h1);
        @(negedge clk);
        p_resv = 0; g_resv = 0;
        #1 check("R6 plain ready again", 8'(p_rdy), 8'h1);
    endtask

    task automatic t_group();
        do_reset();
        @(negedge clk);
        g_need = 3'd3;
        #1 check("R1 group three units", 8'(g_rdy), 8'h1);
        g_need = 3'd4;
        #1 check("R1 group top bit removed", 8'(g_rdy), 8'h0);
        g_cyc(1, 0, 0, 6'b001000, "R2 group first pick");
        g_cyc(1, 1, 6'b001000, 6'b000100, "R2 group second pick");
        g_cyc(1, 1, 6'b000100, 6'b000001, "R2 group third pick");
        g_cyc(1, 1, 6'b000001, 6'b001000, "R3 group reload");
        check("R7 group no error", 8'(g_err), 8'h0);
    endtask

    initial begin
        t_reset_state();
        t_rotation();
        t_bind_in_seq();
        t_bind_dropped();
        t_errors();
        t_priority();
        t_reserved();
        t_group();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule